// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Engine

This block is the bit-level slave side of a single-wire, open-drain, half-duplex bus. A system clock runs it. The parameter `CLKS_PER_US` tells it how many clock cycles make one microsecond, and every bus timing is counted in those cycles. It watches the bus line through a two-flop synchroniser. It recognises bus resets and answers each one with a presence pulse. It turns host-timed write slots into received bits, and during read slots it drives the bit that the layer above offers. The `overdrive` input selects the fast timing set in place of the standard one. All thresholds follow that input.

The layer above assembles bytes and decodes commands. It must present a bit on `tx_bit` in every cycle where `tx_req` is high. A value of 1 leaves the line released, so 1 is the correct value for write slots. Received bits appear as a one-cycle `rx_valid` strobe. Neither stream can apply back-pressure, because the host owns slot timing. `tx_req` has no matching ready signal, and `rx_valid` carries no ready input, so a consumer must accept every strobe.

Top module: `owire_slave_phy`

## Requirements
- R1: While `rst_n` is low and after it is released, `pull_low`, `rx_valid`, `reset_detected` and `tx_req` are 0 until the line is seen going low.
- R2: A falling edge on `dq_in` before clock edge k makes `tx_req` high for exactly one cycle, from edge k+1 to edge k+2. This delay is the two-flop synchroniser. That cycle marks a slot start.
- R3: The slot line is sampled 37 µs (standard) or 4 µs (overdrive) after the sensed fall. A high sample gives a one-cycle `rx_valid` with `rx_bit`=1. A low sample gives `rx_valid` with `rx_bit`=0 in the cycle after the rise is sensed.
- R4: If `tx_bit`=0 in the `tx_req` cycle, `pull_low` is high from the next cycle for 30 µs (standard) or 3 µs (overdrive), measured from the sensed fall. This holds the line low beyond the 15 µs / 2 µs valid-data time and releases it before the slot's 60 µs / 6 µs minimum.
- R5: A low that lasts longer than the longest write-0 time (120 µs standard, 16 µs overdrive) ends the slot without any `rx_valid`.
- R6: A sensed low of at least 480 µs (standard) or 48 µs (overdrive) raises `reset_detected` for one cycle while the line is still low. One clock less does not.
- R7: After a reset, once the rise is sensed, the slave waits 37 µs / 4 µs and then holds `pull_low` for 150 µs / 16 µs. The presence pulse therefore falls inside 60–240 µs (standard) or 8–24 µs (overdrive).
- R8: With `overdrive`=1 every threshold in R3–R7 uses its overdrive value.
- R9: `pull_low` is high only during a read-0 hold or a presence pulse. With `tx_bit`=1 a slot is never driven.
- R10: `rx_valid` and `reset_detected` are single-cycle strobes and never occur in the same cycle.
- R11: A write-0 low of exactly the maximum write-0 time in clocks (800 cycles in overdrive at 50 clocks/µs) still yields bit 0. One clock longer aborts the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| overdrive | input | 1 | 1 selects the overdrive timing set |
| dq_in | input | 1 | Raw bus line level, asynchronous |
| pull_low | output | 1 | 1 enables the open-drain pull-down on the line |
| rx_valid | output | 1 | One-cycle strobe: a received bit is on rx_bit |
| rx_bit | output | 1 | Received bit value |
| tx_bit | input | 1 | Bit to send in the slot flagged by tx_req (1 = release) |
| tx_req | output | 1 | One-cycle slot-start strobe; tx_bit is taken in this cycle |
| reset_detected | output | 1 | One-cycle strobe on recognising a bus reset |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the rise that closes a write-0 slot and the count reaching the write-0 limit. The second pair is the rise that ends a long low and the count reaching the reset limit. The bench provokes both by sweeping the host's low time in single-clock steps around each limit in overdrive. A behavioural per-clock model compares `rx_valid`, `rx_bit`, `reset_detected`, `pull_low` and `tx_req` on every cycle. Explicit checks fix which side of each limit delivers a bit, aborts silently, or reports a reset.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,    // line high, waiting for a slot start
    ST_SLOT,    // slot open, counting towards the sample point
    ST_LOW0,    // zero sampled, waiting for host release
    ST_LONG,    // low beyond write-0 limit, counting to reset
    ST_RSTW,    // reset seen, waiting for the line to rise
    ST_PDH,     // gap before presence
    ST_PDL,     // driving presence
    ST_WAITHI   // waiting for the line to return high
  } owire_state_e;

  // Index of each timing limit
  localparam int unsigned LIM_HOLD = 0;
  localparam int unsigned LIM_SAMP = 1;
  localparam int unsigned LIM_W0MAX = 2;
  localparam int unsigned LIM_RST = 3;
  localparam int unsigned LIM_PDH = 4;
  localparam int unsigned LIM_PDL = 5;
  localparam int unsigned LIM_N = 6;

  // Limits in microseconds, indexed as above
  localparam int unsigned STD_US [LIM_N] = '{30, 37, 120, 480, 37, 150};
  localparam int unsigned OVD_US [LIM_N] = '{3, 4, 16, 48, 4, 16};

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owire_timing.sv
module owire_timing
  import owire_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned CNT_W = 16
) (
  input  logic                             overdrive,
  output logic [LIM_N-1:0][CNT_W-1:0]      lims
);
  for (genvar i = 0; i < LIM_N; i++) begin : g_lim
    localparam logic [CNT_W-1:0] STD_C = CNT_W'(STD_US[i] * CLKS_PER_US);
    localparam logic [CNT_W-1:0] OVD_C = CNT_W'(OVD_US[i] * CLKS_PER_US);
    assign lims[i] = overdrive ? OVD_C : STD_C;
  end
endmodule

// File: rtl/owire_slot_fsm.sv
module owire_slot_fsm
  import owire_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dq_s,
  input  logic                        tx_bit,
  input  logic [LIM_N-1:0][CNT_W-1:0] lims,
  output logic                        pull_low,
  output logic                        rx_valid,
  output logic                        rx_bit,
  output logic                        reset_detected,
  output logic                        tx_req
);
  owire_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rst_edge;

  assign tx_req   = (state == ST_IDLE) && !dq_s;
  assign rst_edge = lims[LIM_RST] - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_WAITHI;
      cnt            <= '0;
      pull_low       <= 1'b0;
      rx_valid       <= 1'b0;
      rx_bit         <= 1'b0;
      reset_detected <= 1'b0;
    end else begin
      rx_valid       <= 1'b0;
      reset_detected <= 1'b0;
      unique case (state)
        ST_IDLE: if (!dq_s) begin
          state    <= ST_SLOT;
          cnt      <= CNT_W'(1);
          pull_low <= !tx_bit;
        end
        ST_SLOT: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt >= lims[LIM_HOLD]) pull_low <= 1'b0;
          if (cnt >= lims[LIM_SAMP]) begin
            if (dq_s) begin
              rx_valid <= 1'b1;
              rx_bit   <= 1'b1;
              state    <= ST_WAITHI;
            end else begin
              state <= ST_LOW0;
            end
          end
        end
        ST_LOW0: begin
          cnt <= cnt + CNT_W'(1);
          if (dq_s) begin
            rx_valid <= 1'b1;
            rx_bit   <= 1'b0;
            state    <= ST_IDLE;
          end else if (cnt >= lims[LIM_W0MAX]) begin
            state <= ST_LONG;
          end
        end
        ST_LONG: begin
          if (dq_s) state <= ST_IDLE;
          else if (cnt >= rst_edge) begin
            reset_detected <= 1'b1;
            state          <= ST_RSTW;
          end else cnt <= cnt + CNT_W'(1);
        end
        ST_RSTW: if (dq_s) begin
          state <= ST_PDH;
          cnt   <= CNT_W'(1);
        end
        ST_PDH: begin
          if (cnt >= lims[LIM_PDH]) begin
            pull_low <= 1'b1;
            state    <= ST_PDL;
            cnt      <= CNT_W'(1);
          end else cnt <= cnt + CNT_W'(1);
        end
        ST_PDL: begin
          if (cnt >= lims[LIM_PDL]) begin
            pull_low <= 1'b0;
            state    <= ST_WAITHI;
          end else cnt <= cnt + CNT_W'(1);
        end
        ST_WAITHI: if (dq_s) state <= ST_IDLE;
        default: state <= ST_WAITHI;
      endcase
    end
  end

  // R10
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R10
  rx_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && reset_detected));
  // R6
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_detected |=> !reset_detected);
  // R2
  txreq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);
  // R9
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> (state == ST_SLOT || state == ST_PDL));
  // R4
  read0_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pull_low) && state == ST_SLOT) |-> $past(tx_req && !tx_bit));
  // R7
  presence_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pull_low) && state == ST_PDL) |-> $past(state) == ST_PDH);
endmodule

// File: rtl/owire_slave_phy.sv
module owire_slave_phy
  import owire_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic overdrive,
  input  logic dq_in,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit,
  input  logic tx_bit,
  output logic tx_req,
  output logic reset_detected
);
  localparam int unsigned CNT_W = $clog2(STD_US[LIM_RST] * CLKS_PER_US + 1) + 1;

  logic                        dq_s;
  logic [LIM_N-1:0][CNT_W-1:0] lims;

  owire_sync #(.STAGES(2)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (dq_in),
    .q    (dq_s)
  );

  owire_timing #(.CLKS_PER_US(CLKS_PER_US), .CNT_W(CNT_W)) i_timing (
    .overdrive(overdrive),
    .lims     (lims)
  );

  owire_slot_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .dq_s          (dq_s),
    .tx_bit        (tx_bit),
    .lims          (lims),
    .pull_low      (pull_low),
    .rx_valid      (rx_valid),
    .rx_bit        (rx_bit),
    .reset_detected(reset_detected),
    .tx_req        (tx_req)
  );
endmodule

// File: tb/test_owire_slave_phy.sv
module test_owire_slave_phy;
  localparam int CPU = 50;

  logic clk = 1'b0, rst_n = 1'b0, overdrive = 1'b0, tx_bit = 1'b1, host_low = 1'b0;
  logic dq_in, pull_low, rx_valid, rx_bit, tx_req, reset_detected;
  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  assign dq_in = ~(host_low | pull_low);
  always #10 clk = ~clk;  // 20 time units: one 50 MHz period

  owire_slave_phy #(.CLKS_PER_US(CPU)) i_owire_slave_phy (
    .clk(clk), .rst_n(rst_n), .overdrive(overdrive), .dq_in(dq_in),
    .pull_low(pull_low), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .tx_bit(tx_bit), .tx_req(tx_req), .reset_detected(reset_detected));

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // limits in clocks: 0 hold,1 sample,2 write-0 max,3 reset,4 gap,5 presence
  function automatic int lim(int k, bit od);
    int s[6] = '{30, 37, 120, 480, 37, 150};
    int o[6] = '{3, 4, 16, 48, 4, 16};
    return (od ? o[k] : s[k]) * CPU;
  endfunction

  // behavioural reference, one step per clock
  int m_ph = 7, m_n = 0;
  bit m_s1 = 1, m_s2 = 1, e_pull = 0, e_rxv = 0, e_rxb = 0, e_rst = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_ph = 7; m_n = 0;
      e_pull = 0; e_rxv = 0; e_rxb = 0; e_rst = 0;
    end else begin
      e_rxv = 0; e_rst = 0;
      case (m_ph)
        0: if (!m_s2) begin m_ph = 1; m_n = 1; e_pull = !tx_bit; end
        1: begin
          if (m_n >= lim(0, overdrive)) e_pull = 0;
          if (m_n >= lim(1, overdrive)) begin
            if (m_s2) begin e_rxv = 1; e_rxb = 1; m_ph = 7; end
            else m_ph = 2;
          end
          m_n++;
        end
        2: begin
          if (m_s2) begin e_rxv = 1; e_rxb = 0; m_ph = 0; end
          else if (m_n >= lim(2, overdrive)) m_ph = 3;
          m_n++;
        end
        3: if (m_s2) m_ph = 0;
           else if (m_n >= lim(3, overdrive) - 1) begin e_rst = 1; m_ph = 4; end
           else m_n++;
        4: if (m_s2) begin m_ph = 5; m_n = 1; end
        5: if (m_n >= lim(4, overdrive)) begin e_pull = 1; m_ph = 6; m_n = 1; end
           else m_n++;
        6: if (m_n >= lim(5, overdrive)) begin e_pull = 0; m_ph = 7; end
           else m_n++;
        default: if (m_s2) m_ph = 0;
      endcase
      m_s2 = m_s1; m_s1 = dq_in;
    end
  end

  // per-clock comparison and event monitors
  int rx_cnt = 0, rst_cnt = 0, pull_cnt = 0, plen = 0, last_plen = 0, dlen = 0, last_dlen = 0;
  bit last_rxb = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(pull_low == e_pull, "R4/R7/R9 pull_low", pull_low, e_pull);
      check(rx_valid == e_rxv, "R3 rx_valid", rx_valid, e_rxv);
      if (e_rxv) check(rx_bit == e_rxb, "R3 rx_bit", rx_bit, e_rxb);
      check(reset_detected == e_rst, "R6 reset_detected", reset_detected, e_rst);
      check(tx_req == (m_ph == 0 && !m_s2), "R2 tx_req", tx_req, (m_ph == 0 && !m_s2));
      if (rx_valid) begin rx_cnt++; last_rxb = rx_bit; end
      if (reset_detected) rst_cnt++;
      if (pull_low) begin if (plen == 0) pull_cnt++; plen++; end
      else if (plen != 0) begin last_plen = plen; plen = 0; end
      if (!dq_in) dlen++;
      else if (dlen != 0) begin last_dlen = dlen; dlen = 0; end
    end
  end

  task automatic low_for(int cyc);
    @(negedge clk); host_low = 1'b1;
    repeat (cyc) @(negedge clk);
    host_low = 1'b0;
  endtask
  task automatic idle(int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int r0, p0;
    idle(3);
    // R1 reset state
    check(pull_low == 0, "R1 pull_low", pull_low, 0);
    check(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
    check(reset_detected == 0, "R1 reset_detected", reset_detected, 0);
    rst_n = 1'b1; cmp_on = 1'b1;
    idle(5);
    check(tx_req == 0, "R1 tx_req", tx_req, 0);

    // R6/R7 standard reset and presence
    r0 = rx_cnt;
    low_for(500 * CPU); idle(300 * CPU);
    check(rst_cnt == 1, "R6 std reset count", rst_cnt, 1);
    check(pull_cnt == 1, "R7 presence count", pull_cnt, 1);
    check(last_plen >= 60 * CPU && last_plen <= 240 * CPU, "R7 presence length", last_plen, 150 * CPU);
    check(rx_cnt == r0, "R5 reset gives no bit", rx_cnt, r0);

    // R3 write-1 and write-0
    low_for(5 * CPU); idle(65 * CPU);
    check(rx_cnt == r0 + 1 && last_rxb == 1, "R3 std write-1", last_rxb, 1);
    low_for(70 * CPU); idle(10 * CPU);
    check(rx_cnt == r0 + 2 && last_rxb == 0, "R3 std write-0", last_rxb, 0);
    check(pull_cnt == 1, "R9 no drive in write slots", pull_cnt, 1);

    // R4 read-0, then read-1 with no drive
    tx_bit = 1'b0; low_for(2 * CPU); tx_bit = 1'b1; idle(70 * CPU);
    check(pull_cnt == 2, "R4 read-0 drove line", pull_cnt, 2);
    check(last_dlen >= 15 * CPU && last_dlen < 60 * CPU, "R4 read-0 low time", last_dlen, 30 * CPU);
    p0 = pull_cnt;
    low_for(2 * CPU); idle(70 * CPU);
    check(pull_cnt == p0, "R9 read-1 no drive", pull_cnt, p0);

    // R5 abort: long low below reset
    r0 = rx_cnt;
    low_for(200 * CPU); idle(20 * CPU);
    check(rx_cnt == r0, "R5 abort no bit", rx_cnt, r0);
    check(rst_cnt == 1, "R5 abort no reset", rst_cnt, 1);

    // R8 overdrive timing set
    overdrive = 1'b1; idle(10);
    low_for(50 * CPU); idle(40 * CPU);
    check(rst_cnt == 2, "R8 od reset", rst_cnt, 2);
    check(last_plen >= 8 * CPU && last_plen <= 24 * CPU, "R8 od presence length", last_plen, 16 * CPU);
    r0 = rx_cnt;
    low_for(1 * CPU); idle(8 * CPU);
    check(rx_cnt == r0 + 1 && last_rxb == 1, "R8 od write-1", last_rxb, 1);
    low_for(8 * CPU); idle(3 * CPU);
    check(rx_cnt == r0 + 2 && last_rxb == 0, "R8 od write-0", last_rxb, 0);

    // R11 write-0 limit sweep
    for (int l = 16 * CPU - 2; l <= 16 * CPU + 2; l++) begin
      r0 = rx_cnt;
      low_for(l); idle(200);
      if (l <= 16 * CPU)
        check(rx_cnt == r0 + 1 && last_rxb == 0, "R11 at limit gives 0", rx_cnt - r0, 1);
      else
        check(rx_cnt == r0, "R11 past limit aborts", rx_cnt - r0, 0);
    end

    // R6 reset limit sweep in overdrive
    r0 = rst_cnt;
    low_for(48 * CPU - 1); idle(40 * CPU);
    check(rst_cnt == r0, "R6 one clock short", rst_cnt, r0);
    low_for(48 * CPU); idle(40 * CPU);
    check(rst_cnt == r0 + 1, "R6 at limit", rst_cnt, r0 + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule